// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block keeps the time of day and the date as five packed-BCD registers: seconds, minutes, hours, day of month and month. A binary prescaler counts cycles of an oscillator-rate clock enable. Each time it wraps, it raises a one-cycle tick, and that tick advances the seconds. Carries ripple from seconds to minutes, hours, day and month within the same clock cycle.

Mode flags sit inside the registers themselves:
- Hours bit 6 chooses 12-hour counting (1) or 24-hour counting (0).
- Hours bit 7 is the AM/PM flag (1 = PM).
- Month bit 7 marks a leap year.

A host loads any register with one write port, addressed by a 3-bit select, and reads all five registers at once. A write to seconds also clears the final stages of the prescaler, so a newly set time starts on a fine sub-second boundary.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour mode, AM), day 01 and month 01, with the leap flag clear.
- R2: The prescaler advances on each cycle with `osc_en` high. `sec_tick` is high during the enabled cycle in which the prescaler is all ones, that is, once per 2^PRESC_BITS enabled cycles. The seconds register advances by one at that clock edge.
- R3: Seconds count 00 to 59. On the tick at 59, seconds return to 00 and minutes advance. Minutes count 00 to 59, and on that same carry at minute 59 they return to 00 and hours advance.
- R4: In 24-hour mode (hours bit 6 = 0), hours bits 5:0 count 00 to 23. The step from 23 to 00 advances the day of month.
- R5: In 12-hour mode (hours bit 6 = 1), hours run 12, 01, 02 up to 11, then back to 12. The day advances only on the step from 11 PM to 12.
- R6: The AM/PM flag in hours bit 7 inverts on every step from 11 to 12 in either mode, and also on the step from 23 to 00 in 24-hour mode. The mode bit is never changed by counting.
- R7: The day of month (bits 5:0) rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each rollover advances the month, which (bits 4:0) goes from 12 to 01. The leap flag in month bit 7 is preserved.
- R8: In February the day rolls to 01 after 29 when the leap flag is 1, and after 28 when it is 0. The month then becomes 03.
- R9: A write to seconds clears the top CLR_BITS prescaler stages, keeps the lower stages, and gives no tick in that cycle. A write to any other register leaves the prescaler untouched.
- R10: Write select codes are 0 = seconds, 1 = minutes, 2 = hours, 3 = day, 4 = month. Stored bits are masked:
  - seconds keep bits 6:0;
  - minutes keep bits 6:0;
  - hours keep all 8 bits;
  - day keeps bits 5:0;
  - month keeps bits 7 and 4:0.

  A register written in a tick cycle takes the written value. The other registers still advance as the tick's carries dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable for the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| sec_q | output | 8 | Seconds, BCD |
| min_q | output | 8 | Minutes, BCD |
| hour_q | output | 8 | Hours: bit 7 PM, bit 6 12-hour mode, bits 5:0 BCD |
| day_q | output | 8 | Day of month, BCD |
| mon_q | output | 8 | Month: bit 7 leap flag, bits 4:0 BCD |
| sec_tick | output | 1 | One-cycle second tick (combinational) |

## Verification
`sec_tick` is combinational and is due in the same cycle as the enable that completes the prescaler count. Every register change, whether from a tick carry or a write, appears one edge later. The bench drives inputs just after the falling edge and samples `sec_tick` a moment later in that same cycle. It samples the registers at the next falling edge, after the single register stage.

The bench keeps its own count of the prescaler, including the partial clear caused by a seconds write. From that count it knows the exact enabled cycle in which each tick is due, and it checks that no tick appears before that cycle.

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain #(
  parameter int PRESC_BITS = 15,
  parameter int CLR_BITS   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] day_q,
  output logic [7:0] mon_q,
  output logic       sec_tick
);
  localparam int KEEP = PRESC_BITS - CLR_BITS;

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic [PRESC_BITS-1:0] presc;
  logic wr_s, wr_m, wr_h, wr_d, wr_mo;

  assign wr_s  = wr_en && wr_sel == 3'd0;
  assign wr_m  = wr_en && wr_sel == 3'd1;
  assign wr_h  = wr_en && wr_sel == 3'd2;
  assign wr_d  = wr_en && wr_sel == 3'd3;
  assign wr_mo = wr_en && wr_sel == 3'd4;

  assign sec_tick = osc_en && (&presc) && !wr_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      presc <= '0;
    else if (wr_s)   presc <= {{CLR_BITS{1'b0}}, presc[KEEP-1:0]};
    else if (osc_en) presc <= presc + 1'b1;

  logic       sec_wrap, min_wrap, min_en, hr_en, day_en, mon_en;
  logic       h12, pm, pm_flip, day_wrap;
  logic [5:0] hv, last_day;
  logic [4:0] mv;
  logic [7:0] hour_nx;

  assign sec_wrap = sec_q[6:0] == 7'h59;
  assign min_wrap = min_q[6:0] == 7'h59;
  assign min_en   = sec_tick && sec_wrap;
  assign hr_en    = min_en && min_wrap;

  assign h12 = hour_q[6];
  assign pm  = hour_q[7];
  assign hv  = hour_q[5:0];

  assign pm_flip = h12 ? (hv == 6'h11) : (hv == 6'h11 || hv == 6'h23);
  assign day_en  = hr_en && (h12 ? (hv == 6'h11 && pm) : (hv == 6'h23));

  always_comb begin
    hour_nx = bcd_up({2'b00, hv});
    if (h12 && hv == 6'h12)  hour_nx = 8'h01;
    if (!h12 && hv == 6'h23) hour_nx = 8'h00;
  end

  assign mv = mon_q[4:0];

  always_comb
    case (mv)
      5'h02:                      last_day = mon_q[7] ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase

  assign day_wrap = day_q[5:0] == last_day;
  assign mon_en   = day_en && day_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sec_q <= 8'h00;
    else if (wr_s)     sec_q <= {1'b0, wr_data[6:0]};
    else if (sec_tick) sec_q <= sec_wrap ? 8'h00 : bcd_up(sec_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      min_q <= 8'h00;
    else if (wr_m)   min_q <= {1'b0, wr_data[6:0]};
    else if (min_en) min_q <= min_wrap ? 8'h00 : bcd_up(min_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     hour_q <= 8'h00;
    else if (wr_h)  hour_q <= wr_data;
    else if (hr_en) hour_q <= {pm ^ pm_flip, h12, hour_nx[5:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      day_q <= 8'h01;
    else if (wr_d)   day_q <= {2'b00, wr_data[5:0]};
    else if (day_en) day_q <= day_wrap ? 8'h01 : bcd_up(day_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mon_q <= 8'h01;
    else if (wr_mo)  mon_q <= {wr_data[7], 2'b00, wr_data[4:0]};
    else if (mon_en) mon_q <= {mon_q[7], 2'b00, (mv == 5'h12) ? 5'h01 : bcd_up({3'b000, mv})[4:0]};
endmodule

// File: rtl/bcd_calendar_chain_chk.sv
module bcd_calendar_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] mon_q,
  input logic       sec_tick
);
  a_r2_sec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(wr_en && wr_sel == 3'd0)) |=> $stable(sec_q));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_q == 8'h59) |=> sec_q == 8'h00);

  a_r3_min_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sec_tick && sec_q == 8'h59) && !(wr_en && wr_sel == 3'd1)) |=> $stable(min_q));

  a_r6_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_q == 8'h59 && min_q == 8'h59 && hour_q[5:0] == 6'h11
     && !(wr_en && wr_sel == 3'd2)) |=> hour_q[7] != $past(hour_q[7]));

  a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd2) |=> hour_q[6] == $past(hour_q[6]));

  a_r7_mon_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == 3'd4) && !(sec_tick && sec_q == 8'h59 && min_q == 8'h59))
    |=> $stable(mon_q));

  a_r8_leap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd4) |=> mon_q[7] == $past(mon_q[7]));
endmodule

bind bcd_calendar_chain bcd_calendar_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .mon_q(mon_q),
  .sec_tick(sec_tick)
);

// File: tb/bcd_calendar_chain_tb.sv
module bcd_calendar_chain_tb;
  localparam int PB   = 3;
  localparam int CB   = 1;
  localparam int PMOD = 1 << PB;
  localparam int LOWM = (1 << (PB - CB)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_q, min_q, hour_q, day_q, mon_q;
  logic sec_tick;

  int checks = 0, fails = 0, pcount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_chain #(.PRESC_BITS(PB), .CLR_BITS(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
    .day_q(day_q), .mon_q(mon_q), .sec_tick(sec_tick)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int m, input int leap);
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 3'd0) pcount = pcount & LOWM;
  endtask

  task automatic osc_run(input int n);
    for (int k = 0; k < n; k++) begin
      osc_en = 1'b1;
      @(negedge clk);
    end
    osc_en = 1'b0;
    pcount = (pcount + n) % PMOD;
  endtask

  task automatic one_sec(input bit check_tick);
    int need;
    need = PMOD - pcount;
    for (int k = 0; k < need; k++) begin
      osc_en = 1'b1;
      #1;
      if (check_tick) chk("R2 tick timing", {7'd0, sec_tick}, {7'd0, k == need - 1});
      @(negedge clk);
    end
    osc_en = 1'b0;
    pcount = 0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sec", sec_q, 8'h00);
    chk("R1 min", min_q, 8'h00);
    chk("R1 hour", hour_q, 8'h00);
    chk("R1 day", day_q, 8'h01);
    chk("R1 mon", mon_q, 8'h01);

    one_sec(1);
    chk("R2 sec after first tick", sec_q, 8'h01);
    for (int n = 2; n <= 120; n++) begin
      one_sec(0);
      chk("R3 sec sweep", sec_q, bcd(n % 60));
      chk("R3 min sweep", min_q, bcd(n / 60));
    end

    set_time(8'h05, 8'h59, 8'h59);
    one_sec(0);
    chk("R3 hour carry", hour_q, 8'h06);
    chk("R3 min wrap", min_q, 8'h00);

    osc_run(6);
    wr(3'd0, 8'h30);
    one_sec(1);
    chk("R9 sec after partial clear", sec_q, 8'h31);
    osc_run(3);
    wr(3'd1, 8'h10);
    one_sec(1);
    chk("R9 other write keeps prescaler", min_q, 8'h10);

    for (int h = 0; h < 24; h++) begin
      int pm0;
      logic [7:0] exp_h;
      pm0 = h % 2;
      wr(3'd3, 8'h05); wr(3'd4, 8'h03);
      set_time(8'((pm0 << 7)) | bcd(h), 8'h59, 8'h59);
      one_sec(0);
      exp_h = 8'(((pm0 ^ ((h == 11 || h == 23) ? 1 : 0)) << 7)) | bcd((h + 1) % 24);
      chk("R4 R6 24h hour step", hour_q, exp_h);
      chk("R4 24h day carry", day_q, (h == 23) ? 8'h06 : 8'h05);
    end

    for (int h = 1; h <= 12; h++) begin
      for (int pm0 = 0; pm0 < 2; pm0++) begin
        logic [7:0] exp_h;
        wr(3'd3, 8'h05); wr(3'd4, 8'h03);
        set_time(8'((pm0 << 7) | 64) | bcd(h), 8'h59, 8'h59);
        one_sec(0);
        exp_h = 8'(((pm0 ^ ((h == 11) ? 1 : 0)) << 7) | 64) | bcd((h == 12) ? 1 : h + 1);
        chk("R5 R6 12h hour step", hour_q, exp_h);
        chk("R5 12h day carry", day_q, (h == 11 && pm0 == 1) ? 8'h06 : 8'h05);
      end
    end

    for (int m = 1; m <= 12; m++) begin
      for (int lp = 0; lp < 2; lp++) begin
        logic [7:0] mreg;
        int len;
        mreg = 8'(lp << 7) | bcd(m);
        len = mlen(m, lp);
        wr(3'd4, mreg);
        wr(3'd3, bcd(len - 1));
        set_time(8'h23, 8'h59, 8'h59);
        one_sec(0);
        chk("R7 R8 day to last", day_q, bcd(len));
        chk("R7 R8 month held", mon_q, mreg);
        set_time(8'h23, 8'h59, 8'h59);
        one_sec(0);
        chk("R7 R8 day rollover", day_q, 8'h01);
        chk("R7 R8 month advance", mon_q, 8'(lp << 7) | bcd(m % 12 + 1));
      end
    end

    set_time(8'h03, 8'h59, 8'h59);
    osc_run(PMOD - 1 - pcount);
    osc_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h20;
    @(negedge clk);
    osc_en = 1'b0; wr_en = 1'b0; pcount = 0;
    chk("R10 written min wins", min_q, 8'h20);
    chk("R10 sec still wraps", sec_q, 8'h00);
    chk("R10 hour still advances", hour_q, 8'h04);

    wr(3'd0, 8'hFF); chk("R10 sec mask", sec_q, 8'h7F);
    wr(3'd1, 8'hFF); chk("R10 min mask", min_q, 8'h7F);
    wr(3'd2, 8'hFF); chk("R10 hour mask", hour_q, 8'hFF);
    wr(3'd3, 8'hFF); chk("R10 day mask", day_q, 8'h3F);
    wr(3'd4, 8'hFF); chk("R10 mon mask", mon_q, 8'h9F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule